// File: doc/BRIEF.md
# Serial Divider-Setting Loader With Four-Way Routing

This block takes a three-wire serial stream (bit clock, data, load strobe) from a host and turns it into the parallel settings of a dual frequency-synthesizer core. Bits are collected in a 23-bit shift word. When the load strobe rises, the first two bits of that word choose one of four holding registers: the IF reference divider, the RF reference divider, the IF main divider or the RF main divider. The rest of the word is then decoded with the field layout of that register and stored.

All three serial inputs are brought into the system clock domain through a synchronizer chain, and their edges are detected there. A word that carries a divisor below three is rejected. The target register keeps its old contents and a one-cycle error pulse is raised. Each register has a flag that shows it has been written at least once since reset.

Bit positions below are counted in arrival order: position 1 is the first bit shifted in. Inside each multi-bit field the least significant bit arrives first.

Top module: `serial_latch_router`

## Requirements
- R1: After reset every output field is zero, all four written flags are low and the error pulse is low.
- R2: One bit enters the shift word on each rising edge of the serial clock. Only the last 23 bits shifted before the load strobe rises count, so any extra leading bits are dropped.
- R3: Position 1 (route low) and position 2 (route high) pick the destination: 0,0 IF reference, 1,0 RF reference, 0,1 IF main, 1,1 RF main. Only that one register changes.
- R4: In a reference word, positions 3 and 4 are test-select bits 0 and 1. Positions 5 to 18 are the 14-bit reference divisor. Position 19 is the high pump current select. Positions 20 to 23 have no effect.
- R5: In a main word, position 3 is the monitor select, position 4 the prescaler mode and position 5 the phase polarity. Positions 6 to 10 are the 5-bit swallow count and positions 11 to 23 the 13-bit main divisor.
- R6: A reference word whose divisor is below 3, or a main word whose main divisor is below 3, leaves every register unchanged. It raises the error output for exactly one system clock cycle. A legal word raises no error.
- R7: The written flags are valid_o[0] IF reference, [1] RF reference, [2] IF main and [3] RF main. A flag is set by the first accepted write to its register and stays set until reset.
- R8: Serial clock edges that occur while the load strobe is high do not shift the word. Raising the strobe again then stores the same word a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_ld_i | input | 1 | Load strobe (asynchronous) |
| if_ref_tsel_o | output | 2 | IF reference test-select bits |
| if_ref_div_o | output | 14 | IF reference divisor |
| if_ref_cphi_o | output | 1 | IF high pump current select |
| rf_ref_tsel_o | output | 2 | RF reference test-select bits |
| rf_ref_div_o | output | 14 | RF reference divisor |
| rf_ref_cphi_o | output | 1 | RF high pump current select |
| if_main_mon_o | output | 1 | IF monitor select |
| if_main_pre_o | output | 1 | IF prescaler mode |
| if_main_pol_o | output | 1 | IF phase polarity |
| if_main_swal_o | output | 5 | IF swallow count |
| if_main_div_o | output | 13 | IF main divisor |
| rf_main_mon_o | output | 1 | RF monitor select |
| rf_main_pre_o | output | 1 | RF prescaler mode |
| rf_main_pol_o | output | 1 | RF phase polarity |
| rf_main_swal_o | output | 5 | RF swallow count |
| rf_main_div_o | output | 13 | RF main divisor |
| valid_o | output | 4 | Per-register written flags |
| err_o | output | 1 | One-cycle rejected-word pulse |

## Verification
Some properties are checked by the assertions on every cycle:
- at most one register is written per strobe;
- a rejected word leaves both banks untouched and its error pulse lasts one cycle;
- the written flags are sticky;
- the shift word moves only on an enabled edge and takes in the synchronized data bit.

Other behaviour can only be shown by the bench's scenarios, because it needs a whole serial transfer to be decoded. This covers:
- the bit positions and bit order of every field;
- the four routing codes;
- the lowest and highest divisor values;
- over-long words;
- the ignored bits at the end of a reference word;
- edges of the serial clock while the strobe is held high.

// File: rtl/srt_pkg.sv
package srt_pkg;
  parameter int WORD_W   = 23;
  parameter int SEL_W    = 2;
  parameter int NUM_DEST = 4;
  parameter int TSEL_W   = 2;
  parameter int RDIV_W   = 14;
  parameter int SWAL_W   = 5;
  parameter int NDIV_W   = 13;
  parameter int MIN_DIV  = 3;

  // field positions, counted in arrival order (1 = first bit shifted in)
  parameter int POS_TSEL = 3;
  parameter int POS_RDIV = 5;
  parameter int POS_CPHI = 19;
  parameter int POS_MON  = 3;
  parameter int POS_PRE  = 4;
  parameter int POS_POL  = 5;
  parameter int POS_SWAL = 6;
  parameter int POS_NDIV = 11;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic [RDIV_W-1:0] rdiv;
    logic              cphi;
  } ref_fields_t;

  typedef struct packed {
    logic              mon;
    logic              pre;
    logic              pol;
    logic [SWAL_W-1:0] swal;
    logic [NDIV_W-1:0] ndiv;
  } main_fields_t;

  // the bit at arrival position pos sits at index WORD_W-pos of the shift word
  function automatic ref_fields_t decode_ref(word_t w);
    ref_fields_t f;
    for (int i = 0; i < TSEL_W; i++) f.tsel[i] = w[WORD_W-POS_TSEL-i];
    for (int i = 0; i < RDIV_W; i++) f.rdiv[i] = w[WORD_W-POS_RDIV-i];
    f.cphi = w[WORD_W-POS_CPHI];
    return f;
  endfunction

  function automatic main_fields_t decode_main(word_t w);
    main_fields_t f;
    f.mon = w[WORD_W-POS_MON];
    f.pre = w[WORD_W-POS_PRE];
    f.pol = w[WORD_W-POS_POL];
    for (int i = 0; i < SWAL_W; i++) f.swal[i] = w[WORD_W-POS_SWAL-i];
    for (int i = 0; i < NDIV_W; i++) f.ndiv[i] = w[WORD_W-POS_NDIV-i];
    return f;
  endfunction
endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/srt_shifter.sv
module srt_shifter #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)           word_o <= '0;
    else if (shift_en) word_o <= {word_o[W-2:0], bit_i};
  end

  // R2: an enabled edge takes in the presented bit
  p_shift_takes_bit_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (word_o[0] == $past(bit_i)));
  // R8: with no enabled edge the word holds
  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(word_o));
endmodule

// File: rtl/srt_hold_bank.sv
module srt_hold_bank #(
  parameter int W = 17,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        we,
  input  logic [W-1:0]        din,
  output logic [N-1:0][W-1:0] q,
  output logic [N-1:0]        valid
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        q[g]     <= '0;
        valid[g] <= 1'b0;
      end else if (we[g]) begin
        q[g]     <= din;
        valid[g] <= 1'b1;
      end
    end

    // R7: a written flag stays set
    p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      valid[g] |=> valid[g]);
    // R7: a write marks the entry written
    p_write_marks_r7: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> (valid[g] && q[g] == $past(din)));
  end
endmodule

// File: rtl/serial_latch_router.sv
module serial_latch_router
  import srt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_ld_i,
  output logic [TSEL_W-1:0] if_ref_tsel_o,
  output logic [RDIV_W-1:0] if_ref_div_o,
  output logic              if_ref_cphi_o,
  output logic [TSEL_W-1:0] rf_ref_tsel_o,
  output logic [RDIV_W-1:0] rf_ref_div_o,
  output logic              rf_ref_cphi_o,
  output logic              if_main_mon_o,
  output logic              if_main_pre_o,
  output logic              if_main_pol_o,
  output logic [SWAL_W-1:0] if_main_swal_o,
  output logic [NDIV_W-1:0] if_main_div_o,
  output logic              rf_main_mon_o,
  output logic              rf_main_pre_o,
  output logic              rf_main_pol_o,
  output logic [SWAL_W-1:0] rf_main_swal_o,
  output logic [NDIV_W-1:0] rf_main_div_o,
  output logic [NUM_DEST-1:0] valid_o,
  output logic              err_o
);
  localparam int REF_W  = $bits(ref_fields_t);
  localparam int MAIN_W = $bits(main_fields_t);
  localparam int HALF   = NUM_DEST / 2;
  localparam logic [RDIV_W-1:0] R_MIN = RDIV_W'(MIN_DIV);
  localparam logic [NDIV_W-1:0] N_MIN = NDIV_W'(MIN_DIV);

  // synchronizer: [2] strobe, [1] bit clock, [0] data
  logic [2:0] raw, syn;
  assign raw = {ser_ld_i, ser_clk_i, ser_dat_i};

  srt_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw), .sync_o(syn)
  );

  logic sclk_d, ld_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      ld_d   <= 1'b0;
    end else begin
      sclk_d <= syn[1];
      ld_d   <= syn[2];
    end
  end

  logic sclk_rise, ld_rise, shift_en;
  assign sclk_rise = syn[1] & ~sclk_d;
  assign ld_rise   = syn[2] & ~ld_d;
  assign shift_en  = sclk_rise & ~syn[2];

  word_t word;
  srt_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_i(syn[0]), .word_o(word)
  );

  // routing and legality
  logic [SEL_W-1:0] dest;
  ref_fields_t      ref_in;
  main_fields_t     main_in;
  logic             bad;
  logic [NUM_DEST-1:0] we;

  always_comb begin
    dest    = {word[WORD_W-2], word[WORD_W-1]};
    ref_in  = decode_ref(word);
    main_in = decode_main(word);
    bad     = dest[SEL_W-1] ? (main_in.ndiv < N_MIN) : (ref_in.rdiv < R_MIN);
    for (int d = 0; d < NUM_DEST; d++)
      we[d] = ld_rise && !bad && (dest == SEL_W'(d));
  end

  logic [HALF-1:0][REF_W-1:0]  ref_q;
  logic [HALF-1:0][MAIN_W-1:0] main_q;

  srt_hold_bank #(.W(REF_W), .N(HALF)) u_ref_bank (
    .clk(clk), .rst(rst), .we(we[HALF-1:0]), .din(ref_in),
    .q(ref_q), .valid(valid_o[HALF-1:0])
  );

  srt_hold_bank #(.W(MAIN_W), .N(HALF)) u_main_bank (
    .clk(clk), .rst(rst), .we(we[NUM_DEST-1:HALF]), .din(main_in),
    .q(main_q), .valid(valid_o[NUM_DEST-1:HALF])
  );

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= ld_rise & bad;
  end

  ref_fields_t  if_ref, rf_ref;
  main_fields_t if_main, rf_main;
  assign if_ref  = ref_q[0];
  assign rf_ref  = ref_q[1];
  assign if_main = main_q[0];
  assign rf_main = main_q[1];

  assign if_ref_tsel_o  = if_ref.tsel;
  assign if_ref_div_o   = if_ref.rdiv;
  assign if_ref_cphi_o  = if_ref.cphi;
  assign rf_ref_tsel_o  = rf_ref.tsel;
  assign rf_ref_div_o   = rf_ref.rdiv;
  assign rf_ref_cphi_o  = rf_ref.cphi;
  assign if_main_mon_o  = if_main.mon;
  assign if_main_pre_o  = if_main.pre;
  assign if_main_pol_o  = if_main.pol;
  assign if_main_swal_o = if_main.swal;
  assign if_main_div_o  = if_main.ndiv;
  assign rf_main_mon_o  = rf_main.mon;
  assign rf_main_pre_o  = rf_main.pre;
  assign rf_main_pol_o  = rf_main.pol;
  assign rf_main_swal_o = rf_main.swal;
  assign rf_main_div_o  = rf_main.ndiv;

  // R3: a strobe writes no more than one register
  p_one_dest_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
  // R6: error pulse lasts a single cycle
  p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
  // R6: a rejected word leaves both banks untouched
  p_reject_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_rise && bad) |=> ($stable(ref_q) && $stable(main_q) && err_o));
endmodule

// File: tb/serial_latch_router_tb.sv
module serial_latch_router_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  if_t, rf_t;
  logic [13:0] if_r, rf_r;
  logic        if_c, rf_c;
  logic        if_m, if_p, if_o, rf_m, rf_p, rf_o;
  logic [4:0]  if_a, rf_a;
  logic [12:0] if_n, rf_n;
  logic [3:0]  vld;
  logic        err;

  serial_latch_router u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
    .if_ref_tsel_o(if_t), .if_ref_div_o(if_r), .if_ref_cphi_o(if_c),
    .rf_ref_tsel_o(rf_t), .rf_ref_div_o(rf_r), .rf_ref_cphi_o(rf_c),
    .if_main_mon_o(if_m), .if_main_pre_o(if_p), .if_main_pol_o(if_o),
    .if_main_swal_o(if_a), .if_main_div_o(if_n),
    .rf_main_mon_o(rf_m), .rf_main_pre_o(rf_p), .rf_main_pol_o(rf_o),
    .rf_main_swal_o(rf_a), .rf_main_div_o(rf_n),
    .valid_o(vld), .err_o(err)
  );

  typedef struct packed {
    logic [1:0] t0, t1; logic [13:0] r0, r1; logic c0, c1;
    logic m0, p0, o0, m1, p1, o1; logic [4:0] a0, a1; logic [12:0] n0, n1;
    logic [3:0] v; logic [7:0] errs;
  } snap_t;

  snap_t model;
  snap_t exp_q[$];
  string tag_q[$];
  event  chk_ev;
  int n_chk = 0, n_bad = 0, err_seen = 0;
  bit done = 1'b0;

  task automatic check(string scen, string req, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s actual=%0d expected=%0d", req, scen, nm, act, exp);
    end
  endtask

  // monitor: count error pulses, compare against the scoreboard on request
  initial forever begin
    @(negedge clk);
    if (err) err_seen++;
  end

  initial forever begin
    snap_t e; string s;
    @(chk_ev);
    e = exp_q.pop_front();
    s = tag_q.pop_front();
    check(s, "R4", "if_tsel", int'(if_t), int'(e.t0));
    check(s, "R4", "if_rdiv", int'(if_r), int'(e.r0));
    check(s, "R4", "if_cphi", int'(if_c), int'(e.c0));
    check(s, "R4", "rf_tsel", int'(rf_t), int'(e.t1));
    check(s, "R4", "rf_rdiv", int'(rf_r), int'(e.r1));
    check(s, "R4", "rf_cphi", int'(rf_c), int'(e.c1));
    check(s, "R5", "if_mon",  int'(if_m), int'(e.m0));
    check(s, "R5", "if_pre",  int'(if_p), int'(e.p0));
    check(s, "R5", "if_pol",  int'(if_o), int'(e.o0));
    check(s, "R5", "if_swal", int'(if_a), int'(e.a0));
    check(s, "R5", "if_ndiv", int'(if_n), int'(e.n0));
    check(s, "R5", "rf_mon",  int'(rf_m), int'(e.m1));
    check(s, "R5", "rf_pre",  int'(rf_p), int'(e.p1));
    check(s, "R5", "rf_pol",  int'(rf_o), int'(e.o1));
    check(s, "R5", "rf_swal", int'(rf_a), int'(e.a1));
    check(s, "R5", "rf_ndiv", int'(rf_n), int'(e.n1));
    check(s, "R7", "valid",   int'(vld),  int'(e.v));
    check(s, "R6", "err_pulses", err_seen, int'(e.errs));
    err_seen = 0;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdat = b; tick(3);
    sclk = 1'b1; tick(3);
    sclk = 1'b0; tick(3);
  endtask

  task automatic strobe();
    sld = 1'b1; tick(8);
    sld = 1'b0; tick(8);
  endtask

  task automatic push(string scen, logic [7:0] errs);
    snap_t e;
    e = model; e.errs = errs;
    exp_q.push_back(e);
    tag_q.push_back(scen);
    ->chk_ev;
    tick(1);
  endtask

  task automatic send_word(logic [1:23] w, int extra);
    for (int k = 0; k < extra; k++) send_bit(k[0]);
    for (int k = 1; k <= 23; k++) send_bit(w[k]);
  endtask

  // reference word: position 1 route low (RF), position 2 route high = 0
  task automatic load_ref(string scen, logic rf, logic [1:0] ts, logic [13:0] r,
                          logic cp, logic [3:0] junk, int extra);
    logic [1:23] w;
    w[1] = rf; w[2] = 1'b0; w[3] = ts[0]; w[4] = ts[1];
    for (int i = 0; i < 14; i++) w[5+i] = r[i];
    w[19] = cp;
    for (int i = 0; i < 4; i++) w[20+i] = junk[i];
    send_word(w, extra);
    strobe();
    if (r >= 14'd3) begin
      if (rf) begin model.t1 = ts; model.r1 = r; model.c1 = cp; model.v[1] = 1'b1; end
      else    begin model.t0 = ts; model.r0 = r; model.c0 = cp; model.v[0] = 1'b1; end
      push(scen, 8'd0);
    end else push(scen, 8'd1);
  endtask

  task automatic build_main(output logic [1:23] w, input logic rf, input logic m,
                            input logic p, input logic o, input logic [4:0] a,
                            input logic [12:0] n);
    w[1] = rf; w[2] = 1'b1; w[3] = m; w[4] = p; w[5] = o;
    for (int i = 0; i < 5; i++)  w[6+i]  = a[i];
    for (int i = 0; i < 13; i++) w[11+i] = n[i];
  endtask

  task automatic apply_main(logic rf, logic m, logic p, logic o, logic [4:0] a, logic [12:0] n);
    if (rf) begin model.m1 = m; model.p1 = p; model.o1 = o; model.a1 = a; model.n1 = n; model.v[3] = 1'b1; end
    else    begin model.m0 = m; model.p0 = p; model.o0 = o; model.a0 = a; model.n0 = n; model.v[2] = 1'b1; end
  endtask

  task automatic load_main(string scen, logic rf, logic m, logic p, logic o,
                           logic [4:0] a, logic [12:0] n, int extra);
    logic [1:23] w;
    build_main(w, rf, m, p, o, a, n);
    send_word(w, extra);
    strobe();
    if (n >= 13'd3) begin apply_main(rf, m, p, o, a, n); push(scen, 8'd0); end
    else push(scen, 8'd1);
  endtask

  initial begin
    model = '0;
    tick(5);
    rst = 1'b0;
    tick(3);
    push("R1 reset state", 8'd0);

    load_ref("R3 IF reference, minimum divisor", 1'b0, 2'b10, 14'd3, 1'b1, 4'b0000, 0);
    load_ref("R3 RF reference, maximum divisor, junk tail", 1'b1, 2'b01, 14'd16383, 1'b0, 4'b1111, 0);
    load_main("R3 IF main, minimum divisor, full swallow", 1'b0, 1'b1, 1'b0, 1'b1, 5'd31, 13'd3, 0);
    load_main("R3 RF main, maximum divisor, zero swallow", 1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 13'd8191, 0);
    load_ref("R6 IF reference divisor 2 rejected", 1'b0, 2'b11, 14'd2, 1'b1, 4'b0101, 0);
    load_main("R6 RF main divisor 0 rejected", 1'b1, 1'b1, 1'b1, 1'b1, 5'd7, 13'd0, 0);
    load_ref("R2 IF reference after five extra leading bits", 1'b0, 2'b01, 14'd1000, 1'b0, 4'b1010, 5);
    load_main("R5 IF main mixed pattern", 1'b0, 1'b0, 1'b1, 1'b1, 5'b10110, 13'h1555, 0);

    // R8: edges while the strobe is high must not shift
    begin
      logic [1:23] w;
      build_main(w, 1'b0, 1'b1, 1'b1, 1'b0, 5'd9, 13'd4000);
      send_word(w, 0);
      sld = 1'b1; tick(8);
      for (int k = 0; k < 3; k++) send_bit(1'b1);
      sld = 1'b0; tick(8);
      apply_main(1'b0, 1'b1, 1'b1, 1'b0, 5'd9, 13'd4000);
      push("R8 first store", 8'd0);
      strobe();
      push("R8 restrobe after clocks under high strobe", 8'd0);
    end

    load_ref("R7 RF reference rewrite keeps flags", 1'b1, 2'b00, 14'd77, 1'b1, 4'b0011, 0);
    tick(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule